// File: doc/BRIEF.md
# Four-Channel Wiper and Store Command Engine

This block sits behind a two-wire serial bus front end and carries out the instruction bytes meant for four digitally set potentiometer channels. Each channel owns one volatile 6-bit wiper register, which drives its tap select output, and four 6-bit store registers. The front end forwards a frame-begin strobe once the device address has matched, then the instruction byte, then an optional data byte, and finally a stop strobe. The engine acknowledges each byte, returns read data, and updates the registers.

Writes to wiper registers take effect at once. Any instruction that changes a store register is held pending and committed only on a valid stop. After the commit, a programming-time model keeps the block busy for a set number of clock cycles, and during that time it ignores the bus entirely. A write-protect input blocks store updates but leaves the wiper registers writable. An increment/decrement mode lets the front end nudge one wiper up or down one step per pulse.

Top module: `potcmd_engine`

## Requirements
- R1: On reset each wiper register takes the value of store slot 0 of its own channel. Reset does not touch the store registers, which start with the value (13*channel + 7*slot + 3) mod 64. After reset busy, byte_ack and rd_data are 0.
- R2: The first byte of a frame is the instruction. Bits 7..4 are the opcode, bits 3..2 select the store slot and bits 1..0 select the channel. Opcodes: 1001 read wiper, 1010 write wiper, 1011 read store, 1100 write store, 1101 store-to-wiper, 1110 wiper-to-store, 0001 all-channel store-to-wiper, 1000 all-channel wiper-to-store, 0010 step mode.
- R3: A read instruction returns {2'b00, value} on rd_data. The value appears in the cycle after the instruction byte is taken.
- R4: Write wiper loads bits 5..0 of the data byte into the selected wiper in the cycle after that byte. Bits 7..6 are ignored, and busy does not assert.
- R5: Store-to-wiper copies the selected slot into the selected wiper. The all-channel form copies that slot of every channel into its own wiper. Both take effect in the cycle after the instruction byte, before any stop.
- R6: Write store, wiper-to-store and the all-channel wiper-to-store change no store register until stop. At stop they commit, and busy is high for exactly BUSY_CYCLES cycles. Reads and wiper-only commands never raise busy.
- R7: A pending store update is dropped when a new frame begins before a stop arrives.
- R8: While busy, frame-begin, bytes, steps and stop are ignored: no byte is acknowledged and no register changes.
- R9: With wp_n low, the data byte of write store is not acknowledged, and no store update commits at a stop seen while wp_n is low. Wiper updates still work. Pulling wp_n low during busy does not undo a commit.
- R10: In step mode each step pulse with step_up=1 raises the selected wiper by one and each pulse with step_up=0 lowers it by one. The value holds at 63 and at 0.
- R11: Undefined opcodes (0000, 0011 to 0111, 1111) are acknowledged and change nothing.
- R12: Outside busy, every byte taken within a frame is acknowledged with byte_ack=1 in the cycle after it. The only exception is the case in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_begin | input | 1 | Address matched, a new frame starts |
| byte_valid | input | 1 | byte_in carries a received byte |
| byte_in | input | 8 | Received instruction or data byte |
| stop | input | 1 | Stop condition seen on the bus |
| step_valid | input | 1 | One step pulse in step mode |
| step_up | input | 1 | Step direction, 1 raises the wiper |
| wp_n | input | 1 | Write protect, low blocks store updates |
| byte_ack | output | 1 | Acknowledge for the byte taken last cycle |
| rd_data | output | 8 | Data to return for a read instruction |
| busy | output | 1 | Programming cycle in progress |
| wipers | output | 24 | Four 6-bit wiper values, channel 0 in bits 5..0 |

## Verification
The hardest states to reach are those where write protect changes between the data byte and the stop, or falls after the commit has started. The bench drives wp_n at exact cycle positions relative to the stop pulse and to the first busy cycle, then reads the slot back. A second hard case is a frame abandoned by a fresh frame-begin while an update is pending. The bench opens a new frame with no stop in between, closes it with a stop, and checks that busy never rises and the slot is unchanged. Step saturation is swept over the whole 0 to 63 range in both directions.

// File: rtl/potcmd_pkg.sv
package potcmd_pkg;

    localparam int NPOT   = 4;
    localparam int NREG   = 4;
    localparam int VAL_W  = 6;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int CELL_W = 2 * SEL_W;
    localparam int NCELL  = NPOT * NREG;
    localparam logic [VAL_W-1:0] VAL_MAX = '1;

    localparam logic [3:0] OPC_LOAD_ALL = 4'b0001;
    localparam logic [3:0] OPC_STEP     = 4'b0010;
    localparam logic [3:0] OPC_SAVE_ALL = 4'b1000;
    localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
    localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
    localparam logic [3:0] OPC_RD_STORE = 4'b1011;
    localparam logic [3:0] OPC_WR_STORE = 4'b1100;
    localparam logic [3:0] OPC_LOAD_ONE = 4'b1101;
    localparam logic [3:0] OPC_SAVE_ONE = 4'b1110;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_WIPER,
        CMD_WR_WIPER,
        CMD_RD_STORE,
        CMD_WR_STORE,
        CMD_LOAD_ONE,
        CMD_SAVE_ONE,
        CMD_LOAD_ALL,
        CMD_SAVE_ALL,
        CMD_STEP
    } cmd_e;

    typedef struct packed {
        cmd_e             cmd;
        logic [SEL_W-1:0] slot;
        logic [SEL_W-1:0] pot;
    } instr_t;

    typedef struct packed {
        logic             valid;
        logic             from_wiper;
        logic             all_pots;
        logic [SEL_W-1:0] slot;
        logic [SEL_W-1:0] pot;
        logic [VAL_W-1:0] val;
    } pend_t;

    function automatic instr_t decode_instr(input logic [BYTE_W-1:0] b);
        instr_t r;
        r.slot = b[3:2];
        r.pot  = b[1:0];
        case (b[7:4])
            OPC_RD_WIPER: r.cmd = CMD_RD_WIPER;
            OPC_WR_WIPER: r.cmd = CMD_WR_WIPER;
            OPC_RD_STORE: r.cmd = CMD_RD_STORE;
            OPC_WR_STORE: r.cmd = CMD_WR_STORE;
            OPC_LOAD_ONE: r.cmd = CMD_LOAD_ONE;
            OPC_SAVE_ONE: r.cmd = CMD_SAVE_ONE;
            OPC_LOAD_ALL: r.cmd = CMD_LOAD_ALL;
            OPC_SAVE_ALL: r.cmd = CMD_SAVE_ALL;
            OPC_STEP:     r.cmd = CMD_STEP;
            default:      r.cmd = CMD_NONE;
        endcase
        return r;
    endfunction

    function automatic logic needs_data(input cmd_e c);
        return (c == CMD_WR_WIPER) || (c == CMD_WR_STORE);
    endfunction

    function automatic logic [CELL_W-1:0] cell_of(input logic [SEL_W-1:0] pot,
                                                  input logic [SEL_W-1:0] slot);
        return {pot, slot};
    endfunction

    function automatic logic [VAL_W-1:0] factory_val(input int pot, input int slot);
        int t;
        t = (pot * 13 + slot * 7 + 3) % (1 << VAL_W);
        return t[VAL_W-1:0];
    endfunction

endpackage

// File: rtl/potcmd_timer.sv
module potcmd_timer #(
    parameter int BUSY_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // R6: a commit always opens a busy window
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/potcmd_seq.sv
module potcmd_seq
    import potcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wp_n,
    input  logic              frame_begin,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              stop,
    input  logic              step_valid,
    output logic              frame_strb,
    output logic              instr_strb,
    output instr_t            instr_now,
    output instr_t            instr_held,
    output logic              data_strb,
    output logic [VAL_W-1:0]  data_val,
    output logic              stop_strb,
    output logic              step_strb,
    output logic              byte_ack
);
    logic   in_frame_q;
    logic   [1:0] idx_q;
    instr_t held_q;
    logic   live;
    logic   accept;
    logic   refuse;

    assign live       = !busy;
    assign frame_strb = frame_begin && live;
    assign accept     = byte_valid && live && in_frame_q && !frame_begin;
    assign instr_strb = accept && (idx_q == 2'd0);
    assign instr_now  = decode_instr(byte_in);
    assign instr_held = held_q;
    assign data_strb  = accept && (idx_q == 2'd1) && needs_data(held_q.cmd);
    assign data_val   = byte_in[VAL_W-1:0];
    assign stop_strb  = stop && live && in_frame_q && !frame_begin;
    assign step_strb  = step_valid && live && in_frame_q && (idx_q == 2'd1)
                        && (held_q.cmd == CMD_STEP);
    assign refuse     = data_strb && (held_q.cmd == CMD_WR_STORE) && !wp_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            idx_q      <= 2'd0;
            held_q     <= '0;
            byte_ack   <= 1'b0;
        end else begin
            byte_ack <= accept && !refuse;
            if (frame_strb) begin
                in_frame_q <= 1'b1;
                idx_q      <= 2'd0;
                held_q     <= '0;
            end else if (stop_strb) begin
                in_frame_q <= 1'b0;
            end else if (accept) begin
                if (idx_q != 2'd2) begin
                    idx_q <= idx_q + 2'd1;
                end
                if (instr_strb) begin
                    held_q <= instr_now;
                end
            end
        end
    end

    // R8: nothing is acknowledged for a byte offered while busy
    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> !byte_ack);

    // R12: an acknowledge always answers a byte of the previous cycle
    p_ack_has_byte_r12: assert property (@(posedge clk) disable iff (rst)
        byte_ack |-> $past(byte_valid));

endmodule

// File: rtl/potcmd_bank.sv
module potcmd_bank
    import potcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPOT-1:0]  wcr_we,
    input  logic [VAL_W-1:0] wcr_wd [NPOT],
    input  logic [NCELL-1:0] dr_we,
    input  logic [VAL_W-1:0] dr_wd [NPOT],
    output logic [VAL_W-1:0] wcr_q [NPOT],
    output logic [VAL_W-1:0] dr_q [NCELL]
);
    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        for (genvar r = 0; r < NREG; r++) begin : g_slot
            logic [VAL_W-1:0] cell_q = factory_val(p, r);

            always_ff @(posedge clk) begin
                if (dr_we[p*NREG+r]) begin
                    cell_q <= dr_wd[p];
                end
            end

            assign dr_q[p*NREG+r] = cell_q;
        end

        logic [VAL_W-1:0] wiper_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                wiper_q <= dr_q[p*NREG];
            end else if (wcr_we[p]) begin
                wiper_q <= wcr_wd[p];
            end
        end

        assign wcr_q[p] = wiper_q;

        // R1: leaving reset, the wiper matches slot 0 of its channel
        p_reload_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (wiper_q == $past(dr_q[p*NREG])));
    end

endmodule

// File: rtl/potcmd_engine.sv
module potcmd_engine
    import potcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 250000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_begin,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_in,
    input  logic                   stop,
    input  logic                   step_valid,
    input  logic                   step_up,
    input  logic                   wp_n,
    output logic                   byte_ack,
    output logic [7:0]             rd_data,
    output logic                   busy,
    output logic [NPOT*VAL_W-1:0]  wipers
);
    logic             frame_strb;
    logic             instr_strb;
    logic             data_strb;
    logic             stop_strb;
    logic             step_strb;
    instr_t           instr_now;
    instr_t           instr_held;
    logic [VAL_W-1:0] data_val;

    logic [NPOT-1:0]  wcr_we;
    logic [VAL_W-1:0] wcr_wd [NPOT];
    logic [NCELL-1:0] dr_we;
    logic [VAL_W-1:0] dr_wd [NPOT];
    logic [VAL_W-1:0] wcr_q [NPOT];
    logic [VAL_W-1:0] dr_q [NCELL];

    pend_t            pend_q;
    logic             commit;
    logic [NCELL*VAL_W-1:0] dr_flat;

    potcmd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .wp_n       (wp_n),
        .frame_begin(frame_begin),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .stop       (stop),
        .step_valid (step_valid),
        .frame_strb (frame_strb),
        .instr_strb (instr_strb),
        .instr_now  (instr_now),
        .instr_held (instr_held),
        .data_strb  (data_strb),
        .data_val   (data_val),
        .stop_strb  (stop_strb),
        .step_strb  (step_strb),
        .byte_ack   (byte_ack)
    );

    potcmd_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wcr_we(wcr_we),
        .wcr_wd(wcr_wd),
        .dr_we (dr_we),
        .dr_wd (dr_wd),
        .wcr_q (wcr_q),
        .dr_q  (dr_q)
    );

    potcmd_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(commit),
        .busy (busy)
    );

    assign commit = stop_strb && pend_q.valid && wp_n;

    // Register update selection for wipers and store cells
    always_comb begin
        wcr_we = '0;
        dr_we  = '0;
        for (int p = 0; p < NPOT; p++) begin
            wcr_wd[p] = wcr_q[p];
            dr_wd[p]  = pend_q.from_wiper ? wcr_q[p] : pend_q.val;
        end

        if (instr_strb) begin
            case (instr_now.cmd)
                CMD_LOAD_ONE: begin
                    wcr_we[instr_now.pot] = 1'b1;
                    wcr_wd[instr_now.pot] = dr_q[cell_of(instr_now.pot, instr_now.slot)];
                end
                CMD_LOAD_ALL: begin
                    for (int p = 0; p < NPOT; p++) begin
                        wcr_we[p] = 1'b1;
                        wcr_wd[p] = dr_q[cell_of(SEL_W'(p), instr_now.slot)];
                    end
                end
                default: ;
            endcase
        end

        if (data_strb && (instr_held.cmd == CMD_WR_WIPER)) begin
            wcr_we[instr_held.pot] = 1'b1;
            wcr_wd[instr_held.pot] = data_val;
        end

        if (step_strb) begin
            if (step_up && (wcr_q[instr_held.pot] != VAL_MAX)) begin
                wcr_we[instr_held.pot] = 1'b1;
                wcr_wd[instr_held.pot] = wcr_q[instr_held.pot] + 1'b1;
            end else if (!step_up && (wcr_q[instr_held.pot] != '0)) begin
                wcr_we[instr_held.pot] = 1'b1;
                wcr_wd[instr_held.pot] = wcr_q[instr_held.pot] - 1'b1;
            end
        end

        if (commit) begin
            for (int p = 0; p < NPOT; p++) begin
                if (pend_q.all_pots || (pend_q.pot == SEL_W'(p))) begin
                    dr_we[cell_of(SEL_W'(p), pend_q.slot)] = 1'b1;
                end
            end
        end
    end

    // Pending store update, committed only at stop
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (frame_strb || stop_strb) begin
            pend_q <= '0;
        end else if (instr_strb) begin
            pend_q <= '0;
            if ((instr_now.cmd == CMD_SAVE_ONE) || (instr_now.cmd == CMD_SAVE_ALL)) begin
                pend_q.valid      <= 1'b1;
                pend_q.from_wiper <= 1'b1;
                pend_q.all_pots   <= (instr_now.cmd == CMD_SAVE_ALL);
                pend_q.slot       <= instr_now.slot;
                pend_q.pot        <= instr_now.pot;
            end
        end else if (data_strb && (instr_held.cmd == CMD_WR_STORE)) begin
            pend_q.valid      <= wp_n;
            pend_q.from_wiper <= 1'b0;
            pend_q.all_pots   <= 1'b0;
            pend_q.slot       <= instr_held.slot;
            pend_q.pot        <= instr_held.pot;
            pend_q.val        <= data_val;
        end
    end

    // Read return path
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (instr_strb) begin
            case (instr_now.cmd)
                CMD_RD_WIPER: rd_data <= {{(BYTE_W-VAL_W){1'b0}}, wcr_q[instr_now.pot]};
                CMD_RD_STORE: rd_data <= {{(BYTE_W-VAL_W){1'b0}},
                                          dr_q[cell_of(instr_now.pot, instr_now.slot)]};
                default: ;
            endcase
        end
    end

    for (genvar p = 0; p < NPOT; p++) begin : g_out
        assign wipers[p*VAL_W +: VAL_W] = wcr_q[p];
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_flat
        assign dr_flat[c*VAL_W +: VAL_W] = dr_q[c];
    end

    // R8: the wipers stay still while a programming cycle runs
    p_quiet_busy_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wipers));

    // R6: store cells change only at a commit
    p_store_only_commit_r6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(dr_flat));

    // R9: with protection active outside busy, the store cells hold
    p_protect_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!wp_n && !busy) |=> $stable(dr_flat));

    // R10: a step past the top value leaves the wipers as they were
    p_step_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (step_strb && step_up && (wcr_q[instr_held.pot] == VAL_MAX)) |=> $stable(wipers));

    // R11: an undefined opcode changes neither wipers nor busy
    p_undef_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (instr_strb && (instr_now.cmd == CMD_NONE)) |=> ($stable(wipers) && !busy));

endmodule

// File: tb/tb_potcmd_engine.sv
module tb_potcmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_T     = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_begin = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        stop = 1'b0;
    logic        step_valid = 1'b0;
    logic        step_up = 1'b0;
    logic        wp_n = 1'b1;
    logic        byte_ack;
    logic [7:0]  rd_data;
    logic        busy;
    logic [23:0] wipers;

    int n_chk  = 0;
    int n_fail = 0;
    int wcr_m [4];
    int dr_m  [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    potcmd_engine #(.BUSY_CYCLES(BUSY_T)) dut (
        .clk        (clk),
        .rst        (rst),
        .frame_begin(frame_begin),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .stop       (stop),
        .step_valid (step_valid),
        .step_up    (step_up),
        .wp_n       (wp_n),
        .byte_ack   (byte_ack),
        .rd_data    (rd_data),
        .busy       (busy),
        .wipers     (wipers)
    );

    function automatic int factory(input int p, input int r);
        return (p * 13 + r * 7 + 3) % 64;
    endfunction

    function automatic logic [7:0] ib(input logic [3:0] op, input int slot, input int pot);
        logic [1:0] s;
        logic [1:0] q;
        s = slot[1:0];
        q = pot[1:0];
        return {op, s, q};
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_wipers(input string req);
        for (int p = 0; p < 4; p++) begin
            check_eq(req, $sformatf("wiper %0d", p), int'(wipers[p*6 +: 6]), wcr_m[p]);
        end
    endtask

    task automatic open_frame();
        frame_begin = 1'b1;
        @(negedge clk);
        frame_begin = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        ack        = byte_ack;
    endtask

    task automatic close_frame();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic pulse_step(input logic up);
        step_valid = 1'b1;
        step_up    = up;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_store(input int p, input int r, input string req, output int v);
        logic a;
        open_frame();
        put_byte(ib(4'b1011, r, p), a);
        check_eq(req, "read store instr ack", int'(a), 1);
        v = int'(rd_data);
        close_frame();
    endtask

    task automatic write_wiper(input int p, input logic [7:0] d, input string req);
        logic a;
        open_frame();
        put_byte(ib(4'b1010, 3, p), a);
        put_byte(d, a);
        check_eq(req, "write wiper data ack", int'(a), 1);
        close_frame();
        wcr_m[p] = int'(d[5:0]);
    endtask

    task automatic write_store(input int p, input int r, input logic [7:0] d, input string req);
        logic a;
        int n;
        open_frame();
        put_byte(ib(4'b1100, r, p), a);
        put_byte(d, a);
        check_eq(req, "write store data ack", int'(a), 1);
        check_eq(req, "busy before stop", int'(busy), 0);
        close_frame();
        wait_idle(n);
        check_eq(req, "busy length", n, BUSY_T);
        dr_m[p*4+r] = int'(d[5:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a;
        int v;
        int n;

        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                dr_m[p*4+r] = factory(p, r);
            end
            wcr_m[p] = factory(p, 0);
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_wipers("R1");
        check_eq("R1", "busy after reset", int'(busy), 0);
        check_eq("R1", "ack after reset", int'(byte_ack), 0);
        check_eq("R1", "rd_data after reset", int'(rd_data), 0);

        // R2 R3: read every store slot, field positions from the instruction byte
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                read_store(p, r, "R2", v);
                check_eq("R3", $sformatf("store %0d.%0d", p, r), v, dr_m[p*4+r]);
                check_eq("R6", "read leaves busy low", int'(busy), 0);
            end
        end

        // R4: write wiper with bits 7..6 set, then read back with R3
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] d;
                d = 8'hC0 | 8'((p * 17 + k * 21 + 5) % 64);
                write_wiper(p, d, "R4");
                check_wipers("R4");
                check_eq("R4", "no busy on wiper write", int'(busy), 0);
                open_frame();
                put_byte(ib(4'b1001, 2, p), a);
                check_eq("R3", "read wiper value", int'(rd_data), wcr_m[p]);
                close_frame();
            end
        end

        // R6: single store write commits at stop with a busy window
        write_store(1, 2, 8'hEA, "R6");
        read_store(1, 2, "R6", v);
        check_eq("R6", "store 1.2 after commit", v, 42);

        // R7: pending update dropped by a new frame
        open_frame();
        put_byte(ib(4'b1100, 1, 3), a);
        put_byte(8'h05, a);
        open_frame();
        put_byte(ib(4'b1001, 0, 0), a);
        close_frame();
        check_eq("R7", "no busy after dropped update", int'(busy), 0);
        read_store(3, 1, "R7", v);
        check_eq("R7", "store 3.1 unchanged", v, dr_m[13]);

        // R8: bus ignored while busy
        open_frame();
        put_byte(ib(4'b1100, 3, 0), a);
        put_byte(8'h11, a);
        close_frame();
        dr_m[3] = 17;
        check_eq("R8", "busy raised", int'(busy), 1);
        open_frame();
        put_byte(ib(4'b1010, 0, 2), a);
        check_eq("R8", "instr ack while busy", int'(a), 0);
        put_byte(8'h3F, a);
        check_eq("R8", "data ack while busy", int'(a), 0);
        pulse_step(1'b1);
        close_frame();
        check_wipers("R8");
        wait_idle(n);
        read_store(0, 3, "R8", v);
        check_eq("R8", "store 0.3 committed once", v, 17);

        // R5: single and all-channel store-to-wiper, effective before stop
        open_frame();
        put_byte(ib(4'b1101, 2, 0), a);
        wcr_m[0] = dr_m[2];
        check_wipers("R5");
        close_frame();
        check_eq("R5", "no busy after load", int'(busy), 0);
        for (int r = 0; r < 4; r++) begin
            open_frame();
            put_byte(ib(4'b0001, r, 1), a);
            for (int p = 0; p < 4; p++) wcr_m[p] = dr_m[p*4+r];
            check_wipers("R5");
            close_frame();
        end

        // R6: single and all-channel wiper-to-store
        for (int p = 0; p < 4; p++) write_wiper(p, 8'(50 + p), "R6");
        open_frame();
        put_byte(ib(4'b1110, 0, 2), a);
        check_eq("R6", "no busy before stop", int'(busy), 0);
        close_frame();
        wait_idle(n);
        check_eq("R6", "busy length single save", n, BUSY_T);
        dr_m[8] = 52;
        open_frame();
        put_byte(ib(4'b1000, 1, 0), a);
        close_frame();
        wait_idle(n);
        check_eq("R6", "busy length gang save", n, BUSY_T);
        for (int p = 0; p < 4; p++) dr_m[p*4+1] = 50 + p;
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                read_store(p, r, "R6", v);
                check_eq("R6", $sformatf("store %0d.%0d after saves", p, r), v, dr_m[p*4+r]);
            end
        end

        // R9: write protect
        wp_n = 1'b0;
        open_frame();
        put_byte(ib(4'b1100, 2, 2), a);
        check_eq("R12", "instr ack under protect", int'(a), 1);
        put_byte(8'h01, a);
        check_eq("R9", "data nack under protect", int'(a), 0);
        close_frame();
        check_eq("R9", "no busy under protect", int'(busy), 0);
        open_frame();
        put_byte(ib(4'b1000, 0, 0), a);
        close_frame();
        check_eq("R9", "no busy for gang save", int'(busy), 0);
        write_wiper(3, 8'h07, "R9");
        check_wipers("R9");
        wp_n = 1'b1;
        read_store(2, 2, "R9", v);
        check_eq("R9", "store 2.2 held", v, dr_m[10]);
        read_store(0, 0, "R9", v);
        check_eq("R9", "store 0.0 held", v, dr_m[0]);
        // protect dropped between data byte and stop
        open_frame();
        put_byte(ib(4'b1100, 2, 2), a);
        put_byte(8'h02, a);
        check_eq("R9", "data ack with protect off", int'(a), 1);
        wp_n = 1'b0;
        close_frame();
        check_eq("R9", "no commit with protect at stop", int'(busy), 0);
        wp_n = 1'b1;
        read_store(2, 2, "R9", v);
        check_eq("R9", "store 2.2 still held", v, dr_m[10]);
        // protect raised during busy does not abort
        open_frame();
        put_byte(ib(4'b1100, 2, 2), a);
        put_byte(8'h03, a);
        close_frame();
        wp_n = 1'b0;
        wait_idle(n);
        check_eq("R9", "busy length under late protect", n, BUSY_T);
        wp_n = 1'b1;
        dr_m[10] = 3;
        read_store(2, 2, "R9", v);
        check_eq("R9", "store 2.2 committed", v, 3);

        // R10: step sweep with saturation at both ends
        write_wiper(2, 8'h00, "R10");
        open_frame();
        put_byte(ib(4'b0010, 0, 2), a);
        check_eq("R10", "step instr ack", int'(a), 1);
        pulse_step(1'b0);
        check_eq("R10", "hold at 0", int'(wipers[12 +: 6]), 0);
        for (int k = 1; k <= 65; k++) begin
            pulse_step(1'b1);
            check_eq("R10", "step up", int'(wipers[12 +: 6]), (k > 63) ? 63 : k);
        end
        for (int k = 1; k <= 65; k++) begin
            pulse_step(1'b0);
            check_eq("R10", "step down", int'(wipers[12 +: 6]), (63 - k < 0) ? 0 : 63 - k);
        end
        close_frame();
        wcr_m[2] = 0;
        check_wipers("R10");

        // R11: undefined opcodes
        foreach (dr_m[i]) begin
            if (i < 7) begin
                logic [3:0] op;
                case (i)
                    0: op = 4'b0000;
                    1: op = 4'b0011;
                    2: op = 4'b0100;
                    3: op = 4'b0101;
                    4: op = 4'b0110;
                    5: op = 4'b0111;
                    default: op = 4'b1111;
                endcase
                open_frame();
                put_byte(ib(op, 1, 1), a);
                check_eq("R11", "undefined opcode ack", int'(a), 1);
                put_byte(8'h2A, a);
                close_frame();
                check_eq("R11", "no busy after undefined", int'(busy), 0);
                check_wipers("R11");
            end
        end

        // R12: byte outside a frame is not acknowledged
        put_byte(ib(4'b1001, 0, 0), a);
        check_eq("R12", "byte outside frame", int'(a), 0);

        // R1: reset reloads wipers from the current slot 0
        for (int p = 0; p < 4; p++) write_store(p, 0, 8'(60 - p * 9), "R1");
        for (int p = 0; p < 4; p++) write_wiper(p, 8'h15, "R1");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 4; p++) wcr_m[p] = dr_m[p*4];
        check_wipers("R1");
        read_store(1, 3, "R1", v);
        check_eq("R1", "store kept across reset", v, dr_m[7]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule